// File: doc/BRIEF.md
# Control Video Frame Decoder

The block watches a decimated video raster, one 24-bit pixel per valid cycle, and decides for each frame whether it is ordinary picture content or an in-band control frame. A control frame is marked by header rows: every pixel in the first two rows carries a 24-bit header word. While a control frame is active, the pixels that follow each header pair are not display content. Each one is the 24-bit register word for one LED driver, and the block re-emits it as a tagged write that names the output channel, the register type, the module row and the driver column.

The screen is divided into vertical strips of equal width, five strips of 64 columns by default, and each strip feeds one serial output channel. A frame holds three sections. Each section is a header pair followed by one row per display-module row, 30 by default. The sections address the configuration, global-brightness and per-colour current registers, in that order. While a control frame is active, a level output tells the display path to skip this frame's update. A header pair that is wrong after the first one aborts the decode and raises an error level. Both levels clear at the next vertical sync.

Top module: `ctlf_decoder`

## Requirements
- R1: `vsync` sets the raster position to row 0, column 0. `hsync` moves to column 0 of the next row. A pixel is taken only on a cycle with `pix_valid` high and both syncs low, and only a taken pixel advances the column.
- R2: A frame becomes a control frame only if every taken pixel in columns 0..N_CHAN*CHAN_W-1 of rows 0 and 1 has bits 23:16 equal to 8'hE8 and bits 15:10 equal to 6'b111111. Bits 9:0 are ignored. `skip_frame` rises one cycle after the `hsync` that ends row 1, and it stays high until the next `vsync`.
- R3: In a control frame, each taken pixel on data line L (L = 2..DATA_ROWS+1) of section S (S = 0, 1, 2) produces `wr_valid` high for exactly one cycle, on the cycle after the pixel. That write carries `wr_kind`=S (0 configuration, 1 brightness, 2 current), `wr_row`=L-2 and `wr_data` equal to the pixel. A section spans DATA_ROWS+2 rows, and its first two lines are the header pair.
- R4: Column C maps to `wr_chan` = C / CHAN_W (0 to N_CHAN-1) and `wr_col` = C mod CHAN_W.
- R5: The header pairs of sections 1 and 2 must carry the command bits 6'b101010 and 6'b010101, each with the same sync byte. In a control frame, one mismatching pixel anywhere in such a pair makes `hdr_err` rise one cycle after the `hsync` that ends the pair. From that point no write is made until the next `vsync`, and `skip_frame` stays high.
- R6: Header rows, rows at or beyond 3*(DATA_ROWS+2), and pixels at or beyond column N_CHAN*CHAN_W never produce a write. Extra pixels in a header row do not affect the header match.
- R7: A frame whose first header pair does not match gives no writes, and it holds `skip_frame` and `hdr_err` low.
- R8: While `rst_n` is low at a clock edge, all outputs go to zero after that edge.
- R9: A `vsync` in mid-frame clears `skip_frame` and `hdr_err` one cycle later and restarts detection at row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vsync | input | 1 | Frame start pulse |
| hsync | input | 1 | Line start pulse, between rows |
| pix_valid | input | 1 | Pixel present on `pix_data` |
| pix_data | input | 24 | Pixel word |
| wr_valid | output | 1 | Register write present this cycle |
| wr_chan | output | $clog2(N_CHAN+1) (3) | Output channel index |
| wr_kind | output | 2 | Register type: 0 configuration, 1 brightness, 2 current |
| wr_row | output | $clog2(DATA_ROWS) (5) | Display-module row within the section |
| wr_col | output | $clog2(CHAN_W) (6) | Driver position within the channel |
| wr_data | output | 24 | Register word |
| skip_frame | output | 1 | Current frame is a control frame; do not display it |
| hdr_err | output | 1 | A later header pair failed to match; decode aborted |

## Verification
A write appears on the edge that follows the pixel that caused it. Both flags change on the edge that follows the `hsync` ending a header pair, or the `vsync` that opens a frame. The bench therefore predicts, for each cycle it drives, what the outputs must show one edge later. It compares that prediction 1 ns after that edge, well clear of the next drive. The stimulus places idle cycles, surplus columns, surplus rows, header corruptions at the first and last column, and a mid-frame sync and reset at positions the bench has already scored.

// File: rtl/ctlf_pkg.sv
// Shared types and header constants for the control frame decoder.
// Assumes exactly three register sections per control frame.
package ctlf_pkg;

    typedef enum logic [1:0] {
        FR_SEARCH = 2'd0,   // header pair 0 still being checked
        FR_VIDEO  = 2'd1,   // ordinary picture frame
        FR_CTRL   = 2'd2,   // control frame, writes enabled
        FR_ABORT  = 2'd3    // control frame whose later header failed
    } frame_st_t;

    localparam int          N_SECT    = 3;
    localparam logic [7:0]  SYNC_BYTE = 8'hE8;

    // Expected header bits 23:10 for a section: sync byte, then the
    // two-bit command repeated three times (11, 10, 01 for sections 0..2).
    function automatic logic [13:0] hdr_key(input logic [1:0] sec);
        logic [1:0] pair;
        pair = 2'd3 - sec;
        return {SYNC_BYTE, pair, pair, pair};
    endfunction

endpackage

// File: rtl/ctlf_raster_pos.sv
// Raster position tracker. Splits the row into (section, line) and the
// column into (channel, sub-column) with counters, so no divider is needed.
// Assumes vsync and hsync are single-cycle pulses; pixels on a sync cycle
// are not counted. Section saturates at N_SECT, channel at N_CHAN.
module ctlf_raster_pos #(
    parameter int N_CHAN    = 5,
    parameter int CHAN_W    = 64,
    parameter int SECT_ROWS = 32,
    parameter int CH_W      = 3,
    parameter int SUB_W     = 6,
    parameter int LINE_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              hsync,
    input  logic              pix_valid,
    output logic [CH_W-1:0]   chan_idx,
    output logic [SUB_W-1:0]  sub_col,
    output logic [1:0]        sec_idx,
    output logic [LINE_W-1:0] line_idx
);
    import ctlf_pkg::*;

    // Row position: restart on vsync, step line and section on hsync.
    always_ff @(posedge clk) begin
        if (!rst_n || vsync) begin
            sec_idx  <= 2'd0;
            line_idx <= '0;
        end else if (hsync && sec_idx < 2'(N_SECT)) begin
            if (line_idx == LINE_W'(SECT_ROWS - 1)) begin
                line_idx <= '0;
                sec_idx  <= sec_idx + 2'd1;
            end else begin
                line_idx <= line_idx + LINE_W'(1);
            end
        end
    end

    // Column position: restart on either sync, step per taken pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || vsync || hsync) begin
            chan_idx <= '0;
            sub_col  <= '0;
        end else if (pix_valid && chan_idx < CH_W'(N_CHAN)) begin
            if (sub_col == SUB_W'(CHAN_W - 1)) begin
                sub_col  <= '0;
                chan_idx <= chan_idx + CH_W'(1);
            end else begin
                sub_col <= sub_col + SUB_W'(1);
            end
        end
    end

endmodule

// File: rtl/ctlf_hdr_track.sv
// Header pair checker and frame state. Keeps one running match bit for the
// header pair in progress and judges it on the hsync that closes the pair.
// Assumes the caller qualifies hdr_pix to in-range header pixels.
module ctlf_hdr_track (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vsync,
    input  logic                hsync,
    input  logic                hdr_pix,
    input  logic                pair_end,
    input  logic [1:0]          sec_idx,
    input  logic [13:0]         pix_hdr,
    output ctlf_pkg::frame_st_t state
);
    import ctlf_pkg::*;

    logic match_run;

    // Frame state and running header match.
    always_ff @(posedge clk) begin
        if (!rst_n || vsync) begin
            state     <= FR_SEARCH;
            match_run <= 1'b1;
        end else if (hsync) begin
            if (pair_end) begin
                match_run <= 1'b1;
                if (sec_idx == 2'd0)
                    state <= match_run ? FR_CTRL : FR_VIDEO;
                else if (state == FR_CTRL && !match_run)
                    state <= FR_ABORT;
            end
        end else if (hdr_pix && pix_hdr != hdr_key(sec_idx)) begin
            match_run <= 1'b0;
        end
    end

endmodule

// File: rtl/ctlf_word_out.sv
// Write-port register stage. Turns a data pixel of an active control frame
// into one tagged register write, one cycle after the pixel.
// Assumes take already excludes sync cycles and out-of-range positions.
module ctlf_word_out #(
    parameter int CH_W   = 3,
    parameter int SUB_W  = 6,
    parameter int LINE_W = 5,
    parameter int DROW_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [CH_W-1:0]   chan_idx,
    input  logic [SUB_W-1:0]  sub_col,
    input  logic [1:0]        sec_idx,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [23:0]       pix_data,
    output logic              wr_valid,
    output logic [CH_W-1:0]   wr_chan,
    output logic [1:0]        wr_kind,
    output logic [DROW_W-1:0] wr_row,
    output logic [SUB_W-1:0]  wr_col,
    output logic [23:0]       wr_data
);

    // Strobe: high only for the cycle following a taken data pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_valid <= 1'b0;
        else        wr_valid <= take;
    end

    // Payload: loaded with the write tag and word when a pixel is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_chan <= '0;
            wr_kind <= 2'd0;
            wr_row  <= '0;
            wr_col  <= '0;
            wr_data <= 24'd0;
        end else if (take) begin
            wr_chan <= chan_idx;
            wr_kind <= sec_idx;
            wr_row  <= DROW_W'(line_idx - LINE_W'(2));
            wr_col  <= sub_col;
            wr_data <= pix_data;
        end
    end

endmodule

// File: rtl/ctlf_decoder.sv
// Control video frame decoder top. Recognises a control frame from its
// header rows and re-emits the per-driver words as tagged register writes.
// Assumes full-width rows and single-cycle sync pulses between rows.
module ctlf_decoder #(
    parameter int N_CHAN    = 5,
    parameter int CHAN_W    = 64,
    parameter int DATA_ROWS = 30,
    localparam int SECT_ROWS = DATA_ROWS + 2,
    localparam int CH_W      = $clog2(N_CHAN + 1),
    localparam int SUB_W     = (CHAN_W > 1) ? $clog2(CHAN_W) : 1,
    localparam int LINE_W    = $clog2(SECT_ROWS),
    localparam int DROW_W    = (DATA_ROWS > 1) ? $clog2(DATA_ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              hsync,
    input  logic              pix_valid,
    input  logic [23:0]       pix_data,
    output logic              wr_valid,
    output logic [CH_W-1:0]   wr_chan,
    output logic [1:0]        wr_kind,
    output logic [DROW_W-1:0] wr_row,
    output logic [SUB_W-1:0]  wr_col,
    output logic [23:0]       wr_data,
    output logic              skip_frame,
    output logic              hdr_err
);
    import ctlf_pkg::*;

    logic [CH_W-1:0]   chan_idx;
    logic [SUB_W-1:0]  sub_col;
    logic [1:0]        sec_idx;
    logic [LINE_W-1:0] line_idx;
    frame_st_t         state;
    logic              pix_take, in_area, hdr_line, hdr_pix, pair_end, take;

    ctlf_raster_pos #(
        .N_CHAN(N_CHAN), .CHAN_W(CHAN_W), .SECT_ROWS(SECT_ROWS),
        .CH_W(CH_W), .SUB_W(SUB_W), .LINE_W(LINE_W)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync),
        .pix_valid(pix_valid), .chan_idx(chan_idx), .sub_col(sub_col),
        .sec_idx(sec_idx), .line_idx(line_idx)
    );

    // Position qualifiers shared by the header checker and the write stage.
    always_comb begin
        pix_take = pix_valid && !hsync && !vsync;
        in_area  = sec_idx < 2'(N_SECT) && chan_idx < CH_W'(N_CHAN);
        hdr_line = line_idx < LINE_W'(2);
        hdr_pix  = pix_take && in_area && hdr_line;
        pair_end = sec_idx < 2'(N_SECT) && line_idx == LINE_W'(1);
        take     = pix_take && in_area && !hdr_line && state == FR_CTRL;
    end

    ctlf_hdr_track u_hdr (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync),
        .hdr_pix(hdr_pix), .pair_end(pair_end), .sec_idx(sec_idx),
        .pix_hdr(pix_data[23:10]), .state(state)
    );

    ctlf_word_out #(
        .CH_W(CH_W), .SUB_W(SUB_W), .LINE_W(LINE_W), .DROW_W(DROW_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .take(take), .chan_idx(chan_idx),
        .sub_col(sub_col), .sec_idx(sec_idx), .line_idx(line_idx),
        .pix_data(pix_data), .wr_valid(wr_valid), .wr_chan(wr_chan),
        .wr_kind(wr_kind), .wr_row(wr_row), .wr_col(wr_col),
        .wr_data(wr_data)
    );

    // Frame-level flags decoded from the registered frame state.
    always_comb begin
        skip_frame = state == FR_CTRL || state == FR_ABORT;
        hdr_err    = state == FR_ABORT;
    end

endmodule

// File: rtl/ctlf_decoder_chk.sv
// Port-level property checker for ctlf_decoder, attached by bind below.
// Assumes the synchronous active-low reset of the decoder.
module ctlf_decoder_chk #(
    parameter int N_CHAN = 5,
    parameter int CH_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vsync,
    input logic            hsync,
    input logic            pix_valid,
    input logic            wr_valid,
    input logic [CH_W-1:0] wr_chan,
    input logic [1:0]      wr_kind,
    input logic            skip_frame,
    input logic            hdr_err
);

    // A write always follows a taken pixel.
    p_word_after_pixel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(pix_valid) && !$past(hsync) && !$past(vsync)));

    // Writes stay inside the channel range and the three register types.
    p_word_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_chan < CH_W'(N_CHAN) && wr_kind != 2'd3));

    // Control frame detection only takes effect after a line end.
    p_skip_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(skip_frame) |-> $past(hsync));

    // An abort can only come from an already recognised control frame.
    p_err_from_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_err) |-> ($past(skip_frame) && $past(hsync)));

    // Writes happen only in a live, unaborted control frame.
    p_word_in_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (skip_frame && !hdr_err));

    // A frame start clears both flags.
    p_vsync_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vsync) |-> (!skip_frame && !hdr_err));

endmodule

bind ctlf_decoder ctlf_decoder_chk #(.N_CHAN(N_CHAN), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync),
    .pix_valid(pix_valid), .wr_valid(wr_valid), .wr_chan(wr_chan),
    .wr_kind(wr_kind), .skip_frame(skip_frame), .hdr_err(hdr_err)
);

// File: tb/ctlf_decoder_tb.sv
`timescale 1ns/1ps
// Self-checking bench: reduced geometry, a frame-scenario table walked by
// one loop, then directed reset cases. Every driven cycle is scored one
// clock edge later against a prediction made from the requirements.
module ctlf_decoder_tb;
    localparam int NCH  = 5;
    localparam int CW   = 4;
    localparam int DR   = 3;
    localparam int SR   = DR + 2;
    localparam int COLS = NCH * CW;
    localparam int FULL = 3 * SR + 2;

    // {mode, bad[2:0], bad_row, bad_kind(1=sync byte), bad_col[7:0], rows[7:0]}
    localparam logic [21:0] VECS [0:7] = '{
        {1'b1, 3'b000, 1'b0, 1'b0, 8'd0,  8'(FULL)},
        {1'b0, 3'b000, 1'b0, 1'b0, 8'd0,  8'(FULL)},
        {1'b1, 3'b001, 1'b1, 1'b0, 8'd19, 8'(FULL)},
        {1'b1, 3'b010, 1'b0, 1'b1, 8'd0,  8'(FULL)},
        {1'b1, 3'b100, 1'b1, 1'b0, 8'd7,  8'(FULL)},
        {1'b1, 3'b000, 1'b0, 1'b0, 8'd0,  8'd9},
        {1'b0, 3'b000, 1'b0, 1'b0, 8'd0,  8'(FULL)},
        {1'b1, 3'b000, 1'b0, 1'b0, 8'd0,  8'(FULL)}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync = 1'b0, hsync = 1'b0, pix_valid = 1'b0;
    logic [23:0] pix_data = 24'd0;
    logic        wr_valid, skip_frame, hdr_err;
    logic [2:0]  wr_chan;
    logic [1:0]  wr_kind, wr_row, wr_col;
    logic [23:0] wr_data;

    int total = 0, bad = 0, st = 0;
    bit done = 0;
    logic        exp_v = 0, exp_skip = 0, exp_err = 0;
    logic [2:0]  exp_ch = 0;
    logic [1:0]  exp_kind = 0, exp_row = 0, exp_col = 0;
    logic [23:0] exp_data = 0;
    string       wtag = "R8", ftag = "R8";

    always #2 clk = ~clk;

    ctlf_decoder #(.N_CHAN(NCH), .CHAN_W(CW), .DATA_ROWS(DR)) u_dut (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync),
        .pix_valid(pix_valid), .pix_data(pix_data), .wr_valid(wr_valid),
        .wr_chan(wr_chan), .wr_kind(wr_kind), .wr_row(wr_row),
        .wr_col(wr_col), .wr_data(wr_data), .skip_frame(skip_frame),
        .hdr_err(hdr_err)
    );

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [33:0] act, exp;
        if (exp_v) begin
            act = {wr_valid, wr_chan, wr_kind, wr_row, wr_col, wr_data};
            exp = {1'b1, exp_ch, exp_kind, exp_row, exp_col, exp_data};
        end else begin
            act = {wr_valid, 33'd0};
            exp = 34'd0;
        end
        check(wtag, act, exp);
        check(ftag, {32'd0, skip_frame, hdr_err}, {32'd0, exp_skip, exp_err});
    endtask

    // Score the previous cycle's prediction, then apply new inputs.
    task automatic drive(input logic vs, input logic hs, input logic pv, input logic [23:0] d);
        @(posedge clk); #1;
        check_outputs();
        vsync = vs; hsync = hs; pix_valid = pv; pix_data = d;
    endtask

    function automatic logic [23:0] pix_of(input logic [21:0] v, input int r, input int c);
        logic [23:0] w;
        logic [1:0]  p;
        int sec, line;
        sec = r / SR; line = r % SR;
        if (c >= COLS) return 24'h123456;
        if (v[21] && sec < 3 && line < 2) begin
            p = 2'(3 - sec);
            w = {8'hE8, p, p, p, 10'(c * 37 + r)};
            if (v[18 + sec] && line == int'(v[17]) && c == int'(v[15:8])) begin
                if (v[16]) w[23:16] = 8'hE9;
                else       w[15:10] = 6'b000000;
            end
            return w;
        end
        return {8'(r), 8'(c), 8'(r * 16 + c) ^ 8'h5A};
    endfunction

    function automatic string flag_tag();
        if (st == 3) return "R5";
        if (st == 1) return "R7";
        return "R2";
    endfunction

    task automatic run_frame(input logic [21:0] v);
        int rows;
        rows = int'(v[7:0]);
        drive(1'b1, 1'b0, 1'b0, 24'd0);
        st = 0; exp_v = 0; exp_skip = 0; exp_err = 0;
        wtag = "R9"; ftag = "R9";
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c <= COLS; c++) begin
                logic [23:0] px;
                int sec, line;
                px = pix_of(v, r, c);
                sec = r / SR; line = r % SR;
                drive(1'b0, 1'b0, 1'b1, px);
                ftag = flag_tag();
                exp_v = 0;
                if (c >= COLS || sec >= 3 || line < 2) begin
                    wtag = "R6";
                end else if (st == 2) begin
                    exp_v = 1; exp_ch = 3'(c / CW); exp_col = 2'(c % CW);
                    exp_kind = 2'(sec); exp_row = 2'(line - 2); exp_data = px;
                    wtag = (c / CW != 0) ? "R4" : "R3";
                end else begin
                    wtag = (st == 3) ? "R5" : "R7";
                end
                if (c % 7 == 3) begin
                    drive(1'b0, 1'b0, 1'b0, 24'hE8FC00);
                    exp_v = 0; wtag = "R1";
                end
            end
            drive(1'b0, 1'b1, 1'b0, 24'd0);
            if (r % SR == 1 && r / SR < 3) begin
                int s;
                bit good;
                s = r / SR;
                good = v[21] && !v[18 + s];
                if (s == 0) st = good ? 2 : 1;
                else if (st == 2 && !good) st = 3;
            end
            exp_v = 0; wtag = "R1";
            exp_skip = (st >= 2); exp_err = (st == 3);
            ftag = flag_tag();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_outputs();            // R8: outputs low under reset
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) run_frame(VECS[i]);

        // Directed: reset in the middle of an active control frame (R8).
        run_frame({1'b1, 3'b000, 1'b0, 1'b0, 8'd0, 8'd4});
        drive(1'b0, 1'b0, 1'b1, 24'hE8FC00);
        rst_n = 1'b0;
        exp_v = 0; exp_skip = 0; exp_err = 0; st = 0;
        wtag = "R8"; ftag = "R8";
        drive(1'b0, 1'b0, 1'b0, 24'd0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 24'd0);
        // After reset, a plain video frame must stay silent (R7).
        run_frame(VECS[1]);
        // Final frame start clears flags (R9); flush the last prediction.
        run_frame({1'b1, 3'b010, 1'b1, 1'b0, 8'd3, 8'd8});
        drive(1'b1, 1'b0, 1'b0, 24'd0);
        st = 0; exp_v = 0; exp_skip = 0; exp_err = 0;
        wtag = "R9"; ftag = "R9";
        drive(1'b0, 1'b0, 1'b0, 24'd0);
        drive(1'b0, 1'b0, 1'b0, 24'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule